// File: doc/BRIEF.md
# Dual-Read General Register File with Pointer Views

This block is the working register store of a small 8-bit RISC core. It holds thirty-two 8-bit registers, gives two independent combinational read ports to the ALU operand path, and takes one registered write per clock. An operation can therefore read two operands, compute and write the result back within one clock. The top six registers also appear as three 16-bit pointers, X, Y and Z. A dedicated port rewrites both bytes of one pointer in a single edge, for post-increment and pre-decrement addressing. The Z pointer is also the one used as the constant-table lookup address into program memory.

The block also sits at the bottom of the data address map. A byte-addressed data-space port reaches the registers at addresses 0x00 to 0x1F as if they were ordinary memory. Addresses 0x20 to 0x5F are turned into a 64-location I/O select and strobe interface. Addresses above that range are ignored here, because they belong to SRAM, which is outside this block.

Top module: `gpr_file`

## Requirements
- R1: After reset is asserted (active-low), every register reads as 0x00.
- R2: Read ports A and B each return, combinationally, the current content of the register their own 5-bit address selects, independently of each other.
- R3: When the ALU write enable is high at a rising edge, the addressed register takes the ALU data. A read of that register in the same cycle returns the old value.
- R4: Pointer outputs are formed as X = {r27, r26}, Y = {r29, r28} and Z = {r31, r30}, with the odd register as the high byte.
- R5: Pointer select 0, 1 and 2 picks X, Y and Z. With the pointer write enable high, both bytes of the selected pointer load the 16-bit pointer data at one edge. Select value 3 changes nothing.
- R6: A data-space access with an address from 0x00 to 0x1F reads the register with that index, and writes it when the write flag is set.
- R7: A data-space access with an address from 0x20 to 0x5F raises the I/O select with I/O address = address - 0x20. It passes the write flag and write data through and returns the I/O read data. No register changes.
- R8: A data-space access with an address of 0x60 or above returns 0x00, raises no I/O select and changes no register.
- R9: When writes collide on one register, the ALU write wins over the pointer write, and the pointer write wins over the data-space write.
- R10: With the data-space enable low, the I/O select is low and the data-space port writes nothing. With no write source active, all registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rdAddrA | input | 5 | Operand A register index |
| rdDataA | output | 8 | Operand A value |
| rdAddrB | input | 5 | Operand B register index |
| rdDataB | output | 8 | Operand B value |
| aluWrEn | input | 1 | ALU result write enable |
| aluWrAddr | input | 5 | ALU result register index |
| aluWrData | input | 8 | ALU result value |
| ptrWrEn | input | 1 | Pointer write enable |
| ptrSel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptrWrData | input | 16 | New pointer value |
| ptrX | output | 16 | X pointer view |
| ptrY | output | 16 | Y pointer view |
| ptrZ | output | 16 | Z pointer view |
| dsEn | input | 1 | Data-space access enable |
| dsWe | input | 1 | Data-space write flag |
| dsAddr | input | 16 | Data-space byte address |
| dsWrData | input | 8 | Data-space write value |
| dsRdData | output | 8 | Data-space read value |
| ioSel | output | 1 | I/O window select |
| ioWe | output | 1 | I/O write strobe |
| ioAddr | output | 6 | I/O location index |
| ioWrData | output | 8 | I/O write value |
| ioRdData | input | 8 | I/O read value |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 16-bit data-space address and a 64-entry I/O window. With these values every register index and both edges of each address range (0x1F/0x20, 0x5F/0x60) can be reached. Random ALU and data-space targets are biased toward registers 24 to 31, so that three-way write collisions on pointer bytes happen often. Random addresses are spread over the register range, the I/O window and the region above it.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int REG_COUNT = 32;
  localparam int REG_IDX_W = $clog2(REG_COUNT);
  localparam int PTR_COUNT = 3;
  localparam int PTR_SEL_W = 2;
  localparam int PTR_BASE  = REG_COUNT - 2 * PTR_COUNT;

  typedef struct packed {
    logic                 aluWe;
    logic [REG_IDX_W-1:0] aluIdx;
    logic                 ptrWe;
    logic [PTR_SEL_W-1:0] ptrSel;
    logic                 dsWe;
    logic [REG_IDX_W-1:0] dsIdx;
  } gprStrobe_t;
endpackage

// File: rtl/gpr_ctrl.sv
module gpr_ctrl
  import gpr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int IO_COUNT = 64
) (
  input  logic                     aluWrEn,
  input  logic [REG_IDX_W-1:0]     aluWrAddr,
  input  logic                     ptrWrEn,
  input  logic [PTR_SEL_W-1:0]     ptrSel,
  input  logic                     dsEn,
  input  logic                     dsWe,
  input  logic [ADDR_W-1:0]        dsAddr,
  output gprStrobe_t               strobe,
  output logic                     regHit,
  output logic                     ioHit,
  output logic [$clog2(IO_COUNT)-1:0] ioIdx
);
  localparam int IO_AW   = $clog2(IO_COUNT);
  localparam int IO_BASE = REG_COUNT;
  localparam int IO_END  = IO_BASE + IO_COUNT;

  logic [ADDR_W-1:0] ioOffset;

  always_comb begin
    regHit   = dsEn && (dsAddr < ADDR_W'(REG_COUNT));
    ioHit    = dsEn && (dsAddr >= ADDR_W'(IO_BASE)) && (dsAddr < ADDR_W'(IO_END));
    ioOffset = dsAddr - ADDR_W'(IO_BASE);
    ioIdx    = ioOffset[IO_AW-1:0];

    strobe.aluWe  = aluWrEn;
    strobe.aluIdx = aluWrAddr;
    strobe.ptrWe  = ptrWrEn && (ptrSel < PTR_SEL_W'(PTR_COUNT));
    strobe.ptrSel = ptrSel;
    strobe.dsWe   = regHit && dsWe;
    strobe.dsIdx  = dsAddr[REG_IDX_W-1:0];
  end
endmodule

// File: rtl/gpr_dp.sv
module gpr_dp
  import gpr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  gprStrobe_t               strobe,
  input  logic [DATA_W-1:0]        aluData,
  input  logic [2*DATA_W-1:0]      ptrData,
  input  logic [DATA_W-1:0]        dsData,
  input  logic [REG_IDX_W-1:0]     rdAddrA,
  input  logic [REG_IDX_W-1:0]     rdAddrB,
  output logic [DATA_W-1:0]        rdDataA,
  output logic [DATA_W-1:0]        rdDataB,
  output logic [DATA_W-1:0]        dsRegData,
  output logic [2*DATA_W-1:0]      ptrView [PTR_COUNT]
);
  logic [DATA_W-1:0] regs [REG_COUNT];

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    logic aluHit, dsHit, ptrHit;
    logic [DATA_W-1:0] ptrByte;
    assign aluHit = strobe.aluWe && (strobe.aluIdx == REG_IDX_W'(i));
    assign dsHit  = strobe.dsWe  && (strobe.dsIdx  == REG_IDX_W'(i));
    if (i >= PTR_BASE) begin : g_ptr
      localparam int PI   = (i - PTR_BASE) / 2;
      localparam int HIGH = (i - PTR_BASE) % 2;
      assign ptrHit  = strobe.ptrWe && (strobe.ptrSel == PTR_SEL_W'(PI));
      assign ptrByte = ptrData[HIGH*DATA_W +: DATA_W];
    end else begin : g_plain
      assign ptrHit  = 1'b0;
      assign ptrByte = '0;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       regs[i] <= '0;
      else if (aluHit) regs[i] <= aluData;
      else if (ptrHit) regs[i] <= ptrByte;
      else if (dsHit)  regs[i] <= dsData;
    end
  end

  for (genvar p = 0; p < PTR_COUNT; p++) begin : g_view
    assign ptrView[p] = {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
  end

  assign rdDataA   = regs[rdAddrA];
  assign rdDataB   = regs[rdAddrB];
  assign dsRegData = regs[strobe.dsIdx];
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int IO_COUNT = 64,
  localparam int IO_AW   = $clog2(IO_COUNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_IDX_W-1:0] rdAddrA,
  output logic [DATA_W-1:0]    rdDataA,
  input  logic [REG_IDX_W-1:0] rdAddrB,
  output logic [DATA_W-1:0]    rdDataB,
  input  logic                 aluWrEn,
  input  logic [REG_IDX_W-1:0] aluWrAddr,
  input  logic [DATA_W-1:0]    aluWrData,
  input  logic                 ptrWrEn,
  input  logic [PTR_SEL_W-1:0] ptrSel,
  input  logic [2*DATA_W-1:0]  ptrWrData,
  output logic [2*DATA_W-1:0]  ptrX,
  output logic [2*DATA_W-1:0]  ptrY,
  output logic [2*DATA_W-1:0]  ptrZ,
  input  logic                 dsEn,
  input  logic                 dsWe,
  input  logic [ADDR_W-1:0]    dsAddr,
  input  logic [DATA_W-1:0]    dsWrData,
  output logic [DATA_W-1:0]    dsRdData,
  output logic                 ioSel,
  output logic                 ioWe,
  output logic [IO_AW-1:0]     ioAddr,
  output logic [DATA_W-1:0]    ioWrData,
  input  logic [DATA_W-1:0]    ioRdData
);
  gprStrobe_t        strobe;
  logic              regHit, ioHit;
  logic [DATA_W-1:0] dsRegData;
  logic [2*DATA_W-1:0] ptrView [PTR_COUNT];

  gpr_ctrl #(.ADDR_W(ADDR_W), .IO_COUNT(IO_COUNT)) u_ctrl (
    .aluWrEn(aluWrEn), .aluWrAddr(aluWrAddr), .ptrWrEn(ptrWrEn), .ptrSel(ptrSel),
    .dsEn(dsEn), .dsWe(dsWe), .dsAddr(dsAddr), .strobe(strobe),
    .regHit(regHit), .ioHit(ioHit), .ioIdx(ioAddr)
  );

  gpr_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .aluData(aluWrData),
    .ptrData(ptrWrData), .dsData(dsWrData), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .dsRegData(dsRegData), .ptrView(ptrView)
  );

  assign ptrX     = ptrView[0];
  assign ptrY     = ptrView[1];
  assign ptrZ     = ptrView[2];
  assign ioSel    = ioHit;
  assign ioWe     = ioHit && dsWe;
  assign ioWrData = dsWrData;
  assign dsRdData = regHit ? dsRegData : (ioHit ? ioRdData : '0);
endmodule

// File: rtl/gpr_chk.sv
module gpr_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int IO_AW  = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic                aluWrEn,
  input logic [4:0]          aluWrAddr,
  input logic [DATA_W-1:0]   aluWrData,
  input logic                ptrWrEn,
  input logic [1:0]          ptrSel,
  input logic [2*DATA_W-1:0] ptrWrData,
  input logic                dsEn,
  input logic                dsWe,
  input logic [ADDR_W-1:0]   dsAddr,
  input logic [DATA_W-1:0]   dsRdData,
  input logic                ioSel,
  input logic                ioWe,
  input logic [2*DATA_W-1:0] ptrX,
  input logic [2*DATA_W-1:0] ptrY,
  input logic [2*DATA_W-1:0] ptrZ
);
  AST_ALU_BEATS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    aluWrEn && aluWrAddr == 5'd26 |=> ptrX[DATA_W-1:0] == $past(aluWrData)); // R9
  AST_PTR_BOTH_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    ptrWrEn && ptrSel == 2'd2 && !(aluWrEn && aluWrAddr[4:1] == 4'hF) |=> ptrZ == $past(ptrWrData)); // R5
  AST_IO_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ioSel |-> dsEn && dsAddr >= ADDR_W'(32) && dsAddr < ADDR_W'(96) && ioWe == dsWe); // R7
  AST_ABOVE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    dsEn && dsAddr >= ADDR_W'(96) |-> !ioSel && dsRdData == '0); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !aluWrEn && !ptrWrEn && !dsEn |=> $stable(ptrX) && $stable(ptrY) && $stable(ptrZ)); // R10
  AST_NO_IO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !dsEn |-> !ioSel && !ioWe); // R10
endmodule

bind gpr_file gpr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IO_AW(IO_AW)) u_chk (
  .clk(clk), .rstN(rstN), .aluWrEn(aluWrEn), .aluWrAddr(aluWrAddr), .aluWrData(aluWrData),
  .ptrWrEn(ptrWrEn), .ptrSel(ptrSel), .ptrWrData(ptrWrData), .dsEn(dsEn), .dsWe(dsWe),
  .dsAddr(dsAddr), .dsRdData(dsRdData), .ioSel(ioSel), .ioWe(ioWe),
  .ptrX(ptrX), .ptrY(ptrY), .ptrZ(ptrZ)
);

// File: tb/tb_gpr_file.sv
module tb_gpr_file;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] rdAddrA = '0, rdAddrB = '0, aluWrAddr = '0;
  logic [7:0] rdDataA, rdDataB, aluWrData = '0, dsWrData = '0, dsRdData, ioWrData, ioRdData = '0;
  logic aluWrEn = 1'b0, ptrWrEn = 1'b0, dsEn = 1'b0, dsWe = 1'b0, ioSel, ioWe;
  logic [1:0] ptrSel = '0;
  logic [15:0] ptrWrData = '0, ptrX, ptrY, ptrZ, dsAddr = '0;
  logic [5:0] ioAddr;

  int nChk = 0, nFail = 0;
  logic [7:0] mdl [32];

  always #5 clk = ~clk;

  gpr_file dut (
    .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB),
    .rdDataB(rdDataB), .aluWrEn(aluWrEn), .aluWrAddr(aluWrAddr), .aluWrData(aluWrData),
    .ptrWrEn(ptrWrEn), .ptrSel(ptrSel), .ptrWrData(ptrWrData), .ptrX(ptrX), .ptrY(ptrY),
    .ptrZ(ptrZ), .dsEn(dsEn), .dsWe(dsWe), .dsAddr(dsAddr), .dsWrData(dsWrData),
    .dsRdData(dsRdData), .ioSel(ioSel), .ioWe(ioWe), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioRdData(ioRdData)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expDsRead();
    if (!dsEn) return 8'h00;
    if (dsAddr < 16'h20) return mdl[dsAddr[4:0]];   // R6
    if (dsAddr < 16'h60) return ioRdData;           // R7
    return 8'h00;                                   // R8
  endfunction

  function automatic logic expIoSel();
    return dsEn && dsAddr >= 16'h20 && dsAddr < 16'h60;
  endfunction

  // Next register state: ALU over pointer over data-space (R9)
  function automatic logic [7:0] expNext(input int i);
    if (aluWrEn && aluWrAddr == 5'(i)) return aluWrData;
    if (ptrWrEn && ptrSel != 2'd3 && i == 26 + 2 * int'(ptrSel)) return ptrWrData[7:0];
    if (ptrWrEn && ptrSel != 2'd3 && i == 27 + 2 * int'(ptrSel)) return ptrWrData[15:8];
    if (dsEn && dsWe && dsAddr < 16'h20 && dsAddr[4:0] == 5'(i)) return dsWrData;
    return mdl[i];
  endfunction

  task automatic idle();
    aluWrEn = 0; ptrWrEn = 0; dsEn = 0; dsWe = 0;
  endtask

  // Inputs are driven just after a falling edge; outputs are checked 2 ns later.
  task automatic doCycle();
    logic [7:0] nxt [32];
    #2;
    check("R2 portA", 16'(rdDataA), 16'(mdl[rdAddrA]));
    check("R2 portB", 16'(rdDataB), 16'(mdl[rdAddrB]));
    check("R4 X", ptrX, {mdl[27], mdl[26]});
    check("R4 Y", ptrY, {mdl[29], mdl[28]});
    check("R4 Z", ptrZ, {mdl[31], mdl[30]});
    check("R6/R7/R8 dsRdData", 16'(dsRdData), 16'(expDsRead()));
    check("R7/R10 ioSel", 16'(ioSel), 16'(expIoSel()));
    if (expIoSel()) begin
      check("R7 ioAddr", 16'(ioAddr), dsAddr - 16'h20);
      check("R7 ioWe", 16'(ioWe), 16'(dsWe));
      check("R7 ioWrData", 16'(ioWrData), 16'(dsWrData));
    end
    for (int i = 0; i < 32; i++) nxt[i] = expNext(i);
    @(posedge clk);
    #1;
    for (int i = 0; i < 32; i++) mdl[i] = nxt[i];
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset clears every register
    for (int i = 0; i < 32; i++) begin
      rdAddrA = 5'(i); rdAddrB = 5'(31 - i);
      #1 check("R1 reset value", 16'(rdDataA), 16'h0000);
      #0 doCycle();
    end

    // R3: same-cycle read returns the old value, new value next cycle
    aluWrEn = 1; aluWrAddr = 5'd5; aluWrData = 8'hA5; rdAddrA = 5'd5;
    #1 check("R3 old value during write", 16'(rdDataA), 16'h0000);
    doCycle(); idle();
    #1 check("R3 new value after write", 16'(rdDataA), 16'h00A5);
    doCycle();

    // R9: three-way collision on r26, pointer beats data-space on r29
    aluWrEn = 1; aluWrAddr = 5'd26; aluWrData = 8'h11;
    ptrWrEn = 1; ptrSel = 2'd0; ptrWrData = 16'h2233;
    dsEn = 1; dsWe = 1; dsAddr = 16'h001A; dsWrData = 8'h44;
    doCycle(); idle();
    #1 check("R9 alu over ptr", ptrX, 16'h2211);
    ptrWrEn = 1; ptrSel = 2'd1; ptrWrData = 16'h5566;
    dsEn = 1; dsWe = 1; dsAddr = 16'h001D; dsWrData = 8'h77;
    doCycle(); idle();
    #1 check("R9 ptr over ds", ptrY, 16'h5566);

    // R5: Z update and the unused select value
    ptrWrEn = 1; ptrSel = 2'd2; ptrWrData = 16'hBEEF;
    doCycle(); idle();
    #1 check("R5 Z both bytes", ptrZ, 16'hBEEF);
    ptrWrEn = 1; ptrSel = 2'd3; ptrWrData = 16'hFFFF;
    doCycle(); idle();
    #1 check("R5 select 3 ignored X", ptrX, 16'h2211);
    check("R5 select 3 ignored Z", ptrZ, 16'hBEEF);

    // R6..R8, R10: address boundaries
    dsEn = 1; dsWe = 1; dsAddr = 16'h001F; dsWrData = 8'h3C;
    doCycle(); idle();
    #1 check("R6 write at 0x1F", ptrZ, 16'h3CEF);
    dsEn = 1; dsWe = 1; dsAddr = 16'h0020; dsWrData = 8'h99; ioRdData = 8'h6B;
    #1 check("R7 io index at 0x20", 16'(ioAddr), 16'h0000);
    check("R7 io read data", 16'(dsRdData), 16'h006B);
    doCycle();
    dsAddr = 16'h005F;
    #1 check("R7 io index at 0x5F", 16'(ioAddr), 16'h003F);
    doCycle();
    dsAddr = 16'h0060;
    #1 check("R8 no select at 0x60", 16'(ioSel), 16'h0000);
    doCycle(); idle();
    dsEn = 0; dsWe = 1; dsAddr = 16'h0003; dsWrData = 8'hEE; rdAddrB = 5'd3;
    doCycle(); idle();
    #1 check("R10 disabled write ignored", 16'(rdDataB), 16'h0000);
    doCycle();

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      rdAddrA   = 5'($urandom);
      rdAddrB   = 5'($urandom);
      aluWrEn   = ($urandom % 3) != 0;
      aluWrAddr = ($urandom % 2) ? 5'(24 + $urandom % 8) : 5'($urandom);
      aluWrData = 8'($urandom);
      ptrWrEn   = ($urandom % 3) == 0;
      ptrSel    = 2'($urandom);
      ptrWrData = 16'($urandom);
      dsEn      = ($urandom % 4) != 0;
      dsWe      = 1'($urandom);
      case ($urandom % 5)
        0, 1:    dsAddr = 16'(24 + $urandom % 8);
        2:       dsAddr = 16'($urandom % 32);
        3:       dsAddr = 16'(32 + $urandom % 64);
        default: dsAddr = 16'(96 + $urandom % 65440);
      endcase
      dsWrData  = 8'($urandom);
      ioRdData  = 8'($urandom);
      doCycle();
    end

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule